// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level translation structure that lives in ordinary memory. A root register holds the page frame of the top-level directory. For each request the walker reads one directory entry, then one table entry, and checks the presence, write-permission and user-permission flags of both. On success it sets the accessed flag and, for writes, the dirty flag in memory, and then returns the frame from the table entry joined with the page offset. On failure it returns a fault code.

Only one request is in flight at a time. The requester presents an address, a write flag and a user-mode flag. It may present a new one only while the busy output is low. Memory is reached through a simple port that carries one 32-bit entry per access. The port holds its request until the memory acknowledges it. Supervisor software loads the root register. A load is honoured only when the presented privilege ring is 0.

Top module: `pw_walker`

## Requirements
- R1: After reset, busy, response-valid and memory-request are all low.
- R2: The root register takes bits 31:12 of the load value only when load is high and ring equals 0. The low 12 bits are discarded. Loads from rings 1 to 3 leave the root unchanged.
- R3: The first memory read goes to {root, lin[31:22], 2'b00} and the second to {directory-entry[31:12], lin[21:12], 2'b00}. The memory request, address and direction are held stable until acknowledged.
- R4: If the present flag (bit 0) is clear in the directory entry, the walk ends after that one read. If it is clear in the table entry, the walk ends after the second read. Either case reports code 1 (not present), makes no write and gives a physical address of 0.
- R5: With both entries present, a user-mode request whose user flag (bit 2) is clear at either level reports code 2 and makes no write.
- R6: With both entries present and the user check passed, a write request whose writable flag (bit 1) is clear at either level reports code 3 and makes no write.
- R7: A walk that passes all checks reports code 0 and physical address {table-entry[31:12], lin[11:0]}.
- R8: After a passing check, the accessed flag (bit 5) is set in each entry, and for writes the dirty flag (bit 6) is set in the table entry. An entry is written only if its value changes, and the directory entry is written before the table entry. All other bits, including software bits 11:9, are preserved. All writes complete before the response.
- R9: Busy is high from the accepting clock until the response cycle. Requests presented while busy are ignored. Response-valid is a one-cycle pulse, after which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_ld_i | input | 1 | Root register load strobe |
| root_ring_i | input | 2 | Privilege ring of the loading code |
| root_val_i | input | 32 | Root load value (bits 31:12 kept) |
| req_valid_i | input | 1 | Translation request present |
| req_lin_i | input | 32 | Linear address to translate |
| req_wr_i | input | 1 | Request is a write |
| req_user_i | input | 1 | Request comes from user mode |
| req_busy_o | output | 1 | Walk in progress; requests ignored |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_code_o | output | 2 | 0 ok, 1 not present, 2 user denied, 3 write denied |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Entry value to write |
| mem_ack_i | input | 1 | Memory completes the pending access |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The assertions assume that memory raises its acknowledge only for a pending request, exactly once per access, and that read data is valid in the acknowledge cycle. The bench memory model acknowledges each access one cycle after it is raised and never otherwise. It also assumes that requesters present a request only while busy is low, apart from the deliberate busy-time requests. The bench raises request-valid for one cycle while idle, and keeps its busy-time requests short enough that they end before the response. It sweeps every combination of directory flags, table flags, write and user mode, so each fault priority and each write-back case is reached.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int unsigned VA_W    = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned IDX_W   = 10;
    localparam int unsigned ENT_LOG = 2;
    localparam int unsigned FRAME_W = VA_W - OFF_W;
    localparam int unsigned RING_W  = 2;

    localparam int unsigned FLG_P = 0;
    localparam int unsigned FLG_W = 1;
    localparam int unsigned FLG_U = 2;
    localparam int unsigned FLG_A = 5;
    localparam int unsigned FLG_D = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_DIR, ST_RD_TBL, ST_WB_DIR, ST_WB_TBL, ST_RESP
    } walk_st_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_USER   = 2'd2,
        FLT_WRITE  = 2'd3
    } fault_t;

    typedef struct packed {
        logic [VA_W-1:0] lin;
        logic            wr;
        logic            user;
    } walk_req_t;

    function automatic logic [IDX_W-1:0] dir_idx(input logic [VA_W-1:0] lin);
        return lin[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] tbl_idx(input logic [VA_W-1:0] lin);
        return lin[OFF_W +: IDX_W];
    endfunction

    function automatic logic [VA_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                   input logic [IDX_W-1:0]   idx);
        return {frame, idx, {ENT_LOG{1'b0}}};
    endfunction
endpackage

// File: rtl/pw_root_reg.sv
module pw_root_reg
    import pw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_i,
    input  logic [RING_W-1:0]  ring_i,
    input  logic [VA_W-1:0]    val_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic unused_low_bits;
    assign unused_low_bits = ^val_i[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            frame_o <= '0;
        else if (ld_i && ring_i == '0)
            frame_o <= val_i[VA_W-1:OFF_W];
    end
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check
    import pw_pkg::*;
(
    input  logic            wr_i,
    input  logic            user_i,
    input  logic [VA_W-1:0] dir_ent_i,
    input  logic [VA_W-1:0] tbl_ent_i,
    output fault_t          code_o,
    output logic [VA_W-1:0] dir_next_o,
    output logic [VA_W-1:0] tbl_next_o,
    output logic            dir_upd_o,
    output logic            tbl_upd_o
);
    logic both_user, both_write, both_here;

    assign both_here  = dir_ent_i[FLG_P] & tbl_ent_i[FLG_P];
    assign both_user  = dir_ent_i[FLG_U] & tbl_ent_i[FLG_U];
    assign both_write = dir_ent_i[FLG_W] & tbl_ent_i[FLG_W];

    always_comb begin
        if (!both_here)
            code_o = FLT_ABSENT;
        else if (user_i && !both_user)
            code_o = FLT_USER;
        else if (wr_i && !both_write)
            code_o = FLT_WRITE;
        else
            code_o = FLT_NONE;
    end

    always_comb begin
        dir_next_o        = dir_ent_i;
        dir_next_o[FLG_A] = 1'b1;
        tbl_next_o        = tbl_ent_i;
        tbl_next_o[FLG_A] = 1'b1;
        if (wr_i)
            tbl_next_o[FLG_D] = 1'b1;
    end

    assign dir_upd_o = (dir_next_o != dir_ent_i);
    assign tbl_upd_o = (tbl_next_o != tbl_ent_i);
endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
    import pw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] root_i,
    input  logic               req_valid_i,
    input  walk_req_t          req_i,
    output logic               busy_o,
    output logic               rsp_valid_o,
    output fault_t             rsp_code_o,
    output logic [VA_W-1:0]    rsp_paddr_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [VA_W-1:0]    mem_addr_o,
    output logic [VA_W-1:0]    mem_wdata_o,
    input  logic               mem_ack_i,
    input  logic [VA_W-1:0]    mem_rdata_i
);
    walk_st_t        st;
    walk_req_t       req_q;
    logic [VA_W-1:0] dir_addr_q, tbl_addr_q, dir_ent_q;
    logic [VA_W-1:0] dir_wb_q, tbl_wb_q;
    logic            tbl_upd_q;

    fault_t          chk_code;
    logic [VA_W-1:0] dir_next, tbl_next;
    logic            dir_upd, tbl_upd;

    pw_perm_check u_perm (
        .wr_i       (req_q.wr),
        .user_i     (req_q.user),
        .dir_ent_i  (dir_ent_q),
        .tbl_ent_i  (mem_rdata_i),
        .code_o     (chk_code),
        .dir_next_o (dir_next),
        .tbl_next_o (tbl_next),
        .dir_upd_o  (dir_upd),
        .tbl_upd_o  (tbl_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            req_q       <= '0;
            dir_addr_q  <= '0;
            tbl_addr_q  <= '0;
            dir_ent_q   <= '0;
            dir_wb_q    <= '0;
            tbl_wb_q    <= '0;
            tbl_upd_q   <= 1'b0;
            rsp_code_o  <= FLT_NONE;
            rsp_paddr_o <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid_i) begin
                    req_q      <= req_i;
                    dir_addr_q <= entry_addr(root_i, dir_idx(req_i.lin));
                    st         <= ST_RD_DIR;
                end
                ST_RD_DIR: if (mem_ack_i) begin
                    dir_ent_q <= mem_rdata_i;
                    if (!mem_rdata_i[FLG_P]) begin
                        rsp_code_o  <= FLT_ABSENT;
                        rsp_paddr_o <= '0;
                        st          <= ST_RESP;
                    end else begin
                        tbl_addr_q <= entry_addr(mem_rdata_i[VA_W-1:OFF_W], tbl_idx(req_q.lin));
                        st         <= ST_RD_TBL;
                    end
                end
                ST_RD_TBL: if (mem_ack_i) begin
                    rsp_code_o <= chk_code;
                    if (chk_code != FLT_NONE) begin
                        rsp_paddr_o <= '0;
                        st          <= ST_RESP;
                    end else begin
                        rsp_paddr_o <= {mem_rdata_i[VA_W-1:OFF_W], req_q.lin[OFF_W-1:0]};
                        dir_wb_q    <= dir_next;
                        tbl_wb_q    <= tbl_next;
                        tbl_upd_q   <= tbl_upd;
                        if (dir_upd)      st <= ST_WB_DIR;
                        else if (tbl_upd) st <= ST_WB_TBL;
                        else              st <= ST_RESP;
                    end
                end
                ST_WB_DIR: if (mem_ack_i)
                    st <= tbl_upd_q ? ST_WB_TBL : ST_RESP;
                ST_WB_TBL: if (mem_ack_i)
                    st <= ST_RESP;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (st != ST_IDLE);
    assign rsp_valid_o = (st == ST_RESP);
    assign mem_req_o   = (st == ST_RD_DIR) || (st == ST_RD_TBL) ||
                         (st == ST_WB_DIR) || (st == ST_WB_TBL);
    assign mem_we_o    = (st == ST_WB_DIR) || (st == ST_WB_TBL);
    assign mem_addr_o  = (st == ST_RD_DIR || st == ST_WB_DIR) ? dir_addr_q : tbl_addr_q;
    assign mem_wdata_o = (st == ST_WB_DIR) ? dir_wb_q : tbl_wb_q;
endmodule

// File: rtl/pw_walker.sv
module pw_walker
    import pw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        root_ld_i,
    input  logic [1:0]  root_ring_i,
    input  logic [31:0] root_val_i,
    input  logic        req_valid_i,
    input  logic [31:0] req_lin_i,
    input  logic        req_wr_i,
    input  logic        req_user_i,
    output logic        req_busy_o,
    output logic        rsp_valid_o,
    output logic [1:0]  rsp_code_o,
    output logic [31:0] rsp_paddr_o,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i,
    input  logic [31:0] mem_rdata_i
);
    logic [FRAME_W-1:0] root_frame;
    walk_req_t          req_in;
    fault_t             code;

    assign req_in = '{lin: req_lin_i, wr: req_wr_i, user: req_user_i};

    pw_root_reg u_root (
        .clk     (clk),
        .rst     (rst),
        .ld_i    (root_ld_i),
        .ring_i  (root_ring_i),
        .val_i   (root_val_i),
        .frame_o (root_frame)
    );

    pw_walk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .root_i      (root_frame),
        .req_valid_i (req_valid_i),
        .req_i       (req_in),
        .busy_o      (req_busy_o),
        .rsp_valid_o (rsp_valid_o),
        .rsp_code_o  (code),
        .rsp_paddr_o (rsp_paddr_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i)
    );

    assign rsp_code_o = code;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk
    import pw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               root_ld_i,
    input logic [1:0]         root_ring_i,
    input logic [FRAME_W-1:0] root_frame,
    input logic               req_busy_o,
    input logic               rsp_valid_o,
    input logic [1:0]         rsp_code_o,
    input logic [31:0]        rsp_paddr_o,
    input logic               mem_req_o,
    input logic               mem_we_o,
    input logic [31:0]        mem_addr_o,
    input logic [31:0]        mem_wdata_o,
    input logic               mem_ack_i
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rst)) |-> (!req_busy_o && !rsp_valid_o && !mem_req_o));

    assert_root_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !(root_ld_i && root_ring_i == 2'd0)) |=> $stable(root_frame));

    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_code_o != 2'd0) |-> (rsp_paddr_o == 32'd0));

    assert_wb_accessed_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |-> mem_wdata_o[FLG_A]);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> (!rsp_valid_o && !req_busy_o));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_busy_o |-> (!mem_req_o && !rsp_valid_o));
endmodule

bind pw_walker pw_walker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .root_ld_i   (root_ld_i),
    .root_ring_i (root_ring_i),
    .root_frame  (root_frame),
    .req_busy_o  (req_busy_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_code_o  (rsp_code_o),
    .rsp_paddr_o (rsp_paddr_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i)
);

// File: tb/tb_pw_walker.sv
module tb_pw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        root_ld = 1'b0;
    logic [1:0]  root_ring = 2'd0;
    logic [31:0] root_val = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_wr = 1'b0, req_user = 1'b0;
    logic        busy, rsp_valid, mem_req, mem_we;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    pw_walker dut (
        .clk(clk), .rst(rst), .root_ld_i(root_ld), .root_ring_i(root_ring),
        .root_val_i(root_val), .req_valid_i(req_valid), .req_lin_i(req_lin),
        .req_wr_i(req_wr), .req_user_i(req_user), .req_busy_o(busy),
        .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_paddr_o(rsp_paddr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    // memory model: 4096 words, one-cycle acknowledge, backdoor write port
    logic [31:0] mem [0:4095];
    logic        bd_we = 1'b0;
    logic [31:0] bd_addr = '0, bd_data = '0;
    logic        mon_clr = 1'b0;
    int          rd_cnt, wr_cnt;
    logic [31:0] rd_a0, rd_a1, wr_a0;

    always @(posedge clk) begin
        if (mon_clr) begin
            rd_cnt <= 0; wr_cnt <= 0;
        end
        if (bd_we) mem[bd_addr[13:2]] <= bd_data;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[13:2]];
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                if (!mon_clr) wr_cnt <= wr_cnt + 1;
                if (wr_cnt == 0) wr_a0 <= mem_addr;
            end else begin
                if (!mon_clr) rd_cnt <= rd_cnt + 1;
                if (rd_cnt == 0) rd_a0 <= mem_addr;
                if (rd_cnt == 1) rd_a1 <= mem_addr;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = a; bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic load_root(input logic [31:0] v, input logic [1:0] ring);
        @(negedge clk);
        root_ld = 1'b1; root_val = v; root_ring = ring;
        @(negedge clk);
        root_ld = 1'b0;
    endtask

    // runs one walk; junk>0 drives other requests while busy
    task automatic walk(input logic [31:0] lin, input bit wr, input bit user, input int junk,
                        output logic [1:0] code, output logic [31:0] pa);
        int waited;
        @(negedge clk);
        mon_clr = 1'b1; req_valid = 1'b1; req_lin = lin; req_wr = wr; req_user = user;
        @(negedge clk);
        mon_clr = 1'b0;
        req_valid = (junk > 0);
        req_lin = ~lin; req_wr = ~wr; req_user = ~user;
        if (junk > 0) check(busy == 1'b1, "R9 busy after accept", {31'd0, busy}, 32'd1);
        waited = 0;
        while (!rsp_valid && waited < 64) begin
            @(negedge clk);
            waited++;
            if (waited >= junk) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        if (!rsp_valid) begin
            check(1'b0, "R9 no response", 32'd0, 32'd1);
            code = 2'd0; pa = '0;
        end else begin
            code = rsp_code; pa = rsp_paddr;
            @(negedge clk);
            check(!rsp_valid && !busy, "R9 pulse end", {30'd0, rsp_valid, busy}, 32'd0);
        end
    endtask

    function automatic logic [31:0] mk_ent(input logic [19:0] fr, input logic [4:0] f, input logic [2:0] sw);
        // f = {D,A,U,W,P}
        return {fr, sw, 2'b00, f[4], f[3], 2'b00, f[2], f[1], f[0]};
    endfunction

    logic [1:0]  c;
    logic [31:0] p;

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !rsp_valid && !mem_req, "R1 reset idle",
              {29'd0, busy, rsp_valid, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rsp_valid && !mem_req, "R1 after release",
              {29'd0, busy, rsp_valid, mem_req}, 32'd0);
        load_root(32'h0000_1000, 2'd0);

        // near-exhaustive sweep of flags, write and user
        for (int pf = 0; pf < 16; pf++) begin
            for (int tf = 0; tf < 32; tf++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [9:0]  d, t;
                    logic [11:0] off;
                    logic [31:0] pde, pte, pde_a, pte_a, lin, exp_pa, tbase, pte_e, pde_e;
                    logic [1:0]  exp_c;
                    bit wr, user, ok;
                    int exp_w, exp_r;
                    string tg;
                    wr = m[0]; user = m[1];
                    d = 10'(pf * 32 + tf);
                    t = 10'((tf * 37 + m * 5 + pf) % 1024);
                    off = 12'((pf * tf * 13 + m * 7) & 12'hfff);
                    tbase = (m[0] ^ pf[0]) ? 32'h3000 : 32'h2000;
                    // PDE flags {A,U,W,P} from pf, D bit clear
                    pde = mk_ent(tbase[31:12], {1'b0, pf[3], pf[2], pf[1], pf[0]}, 3'b101);
                    pte = mk_ent(20'(32'h5A000 + pf * 64 + tf), tf[4:0], 3'(tf + m));
                    pde_a = 32'h1000 + {20'd0, d, 2'b00};
                    pte_a = tbase + {20'd0, t, 2'b00};
                    poke(pde_a, pde);
                    poke(pte_a, pte);
                    lin = {d, t, off};
                    walk(lin, wr, user, 0, c, p);
                    exp_r = 2;
                    exp_pa = 32'd0;
                    ok = 1'b0;
                    if (!pde[0]) begin exp_c = 2'd1; exp_r = 1; tg = "R4 absent dir"; end
                    else if (!pte[0]) begin exp_c = 2'd1; tg = "R4 absent tbl"; end
                    else if (user && !(pde[2] && pte[2])) begin exp_c = 2'd2; tg = "R5 user denied"; end
                    else if (wr && !(pde[1] && pte[1])) begin exp_c = 2'd3; tg = "R6 write denied"; end
                    else begin
                        exp_c = 2'd0; tg = "R7 success"; ok = 1'b1;
                        exp_pa = {pte[31:12], off};
                    end
                    pde_e = ok ? (pde | 32'h20) : pde;
                    pte_e = ok ? (pte | 32'h20 | (wr ? 32'h40 : 32'h0)) : pte;
                    exp_w = int'(pde_e != pde) + int'(pte_e != pte);
                    check(c == exp_c, tg, {30'd0, c}, {30'd0, exp_c});
                    check(p == exp_pa, tg, p, exp_pa);
                    check(rd_cnt == exp_r, "R4 read count", rd_cnt, exp_r);
                    check(rd_a0 == pde_a, "R3 dir addr", rd_a0, pde_a);
                    if (exp_r == 2) check(rd_a1 == pte_a, "R3 tbl addr", rd_a1, pte_a);
                    check(wr_cnt == exp_w, "R8 write count", wr_cnt, exp_w);
                    check(mem[pde_a[13:2]] == pde_e, "R8 dir entry", mem[pde_a[13:2]], pde_e);
                    check(mem[pte_a[13:2]] == pte_e, "R8 tbl entry", mem[pte_a[13:2]], pte_e);
                    if (exp_w == 2) check(wr_a0 == pde_a, "R8 dir first", wr_a0, pde_a);
                end
            end
        end

        // root loads: dir at 0x1000 -> table 0x2000, dir at 0x0000 -> table 0x3000
        poke(32'h1000 + 32'd20, mk_ent(20'h00002, 5'b00111, 3'd0));
        poke(32'h2000 + 32'd28, mk_ent(20'hAAAAA, 5'b00111, 3'd0));
        poke(32'h0000 + 32'd20, mk_ent(20'h00003, 5'b00111, 3'd0));
        poke(32'h3000 + 32'd28, mk_ent(20'hBBBBB, 5'b00111, 3'd0));
        walk({10'd5, 10'd7, 12'h123}, 1'b0, 1'b0, 0, c, p);
        check(p == 32'hAAAAA123, "R2 root base", p, 32'hAAAAA123);
        load_root(32'h0000_0000, 2'd3);
        walk({10'd5, 10'd7, 12'h123}, 1'b0, 1'b0, 0, c, p);
        check(p == 32'hAAAAA123, "R2 ring3 load ignored", p, 32'hAAAAA123);
        load_root(32'h0000_0000, 2'd1);
        walk({10'd5, 10'd7, 12'h123}, 1'b0, 1'b0, 0, c, p);
        check(p == 32'hAAAAA123, "R2 ring1 load ignored", p, 32'hAAAAA123);
        load_root(32'h0000_0FFF, 2'd0);
        walk({10'd5, 10'd7, 12'h456}, 1'b0, 1'b0, 0, c, p);
        check(p == 32'hBBBBB456, "R2 ring0 load low bits dropped", p, 32'hBBBBB456);
        check(rd_a0 == 32'h0000_0014, "R3 dir addr new root", rd_a0, 32'h14);
        load_root(32'h0000_1ABC, 2'd0);

        // requests while busy are ignored
        walk({10'd5, 10'd7, 12'h789}, 1'b1, 1'b1, 3, c, p);
        check(c == 2'd0 && p == 32'hAAAAA789, "R9 busy requests ignored", p, 32'hAAAAA789);
        repeat (4) @(negedge clk);
        check(!busy && !mem_req, "R9 no extra walk", {30'd0, busy, mem_req}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule